// File: doc/BRIEF.md
# Character-Cell CRT Timing Generator

This block produces the raster timing for a text-style display built from character cells. A character counter steps once per clock to form each scan line. A scan-line counter steps once per line inside a character row. A row counter steps once per row. At the end of the last row, an optional adjust phase adds a few extra scan lines before the next frame begins. The outputs are horizontal sync, vertical sync, a display-enable strobe and a video memory address. The high part of that address is a per-row base plus the character count. The low part is the scan line within the row.

The timing values are set through a two-step write port. A first write picks a register index. A later data write loads the selected register. The vertical counters stay where they are when a setting is changed, so a new configuration takes effect from the next frame boundary. All outputs come from registers. The enable strobe and the address lag the counter state by one clock.

Top module: `crt_char_timer`

## Requirements
- R1: While `rst` is high, `hsync`, `vsync`, `de` and `vma` are zero from the clock after reset is sampled.
- R2: A write with `sel_we` latches `sel_idx`. A later write with `dat_we` loads `dat` into the register at that index. Index 0 is the line total, 1 is the displayed characters, 2 is the hsync position, 3 is the sync widths (bits 3:0 horizontal, bits 7:4 vertical), 4 is the row total, 5 is the adjust lines, 6 is the displayed rows, 7 is the vsync row, 9 is the last scan line of a row, 12 is the start address high bits and 13 is the start address low byte.
- R3: A scan line lasts (index 0 value + 1) clocks, so consecutive `hsync` rising edges are that far apart.
- R4: On each displayed line, `de` is high for exactly (index 1 value) consecutive clocks.
- R5: `hsync` rises (index 2 value) clocks after `de` rises on the same line. It stays high for (index 3 bits 3:0) clocks, and a width of zero gives no pulse.
- R6: A frame lasts ((index 4 + 1)·(index 9 + 1) + index 5) lines. The adjust lines carry no `de`.
- R7: `de` is high for (index 1)·(index 6)·(index 9 + 1) clocks per frame, counting only rows below the index 6 value.
- R8: `vsync` rises on the first clock of row (index 7). It lasts (index 3 bits 7:4) lines, or 16 lines when that field is zero.
- R9: While `de` is high, `vma` equals {start + row·(index 1) + column, scan line[2:0]}, with the first part taken modulo 2^14. The row base reloads from the start address at each frame start and advances by index 1 at each row end.
- R10: Data writes while index 8, 10, 11 or 14 to 31 is selected change no timing or address behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Register index write strobe |
| sel_idx | input | 5 | Register index |
| dat_we | input | 1 | Register data write strobe |
| dat | input | 8 | Register data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| vma | output | 17 | Video memory address {char address, scan line} |

## Verification
Three events can land in the same clock: the start of horizontal sync, the line wrap and the vertical step. One configuration places the hsync position equal to the line total, so sync starts in the very cycle the line ends. That cycle also increments the row, starts vertical sync and reloads the row base. The bench judges this by the hsync period and offset, the vsync alignment with the first displayed clock of the frame, and by addresses that wrap past the top of the 14-bit space.

// File: rtl/crt_char_pkg.sv
package crt_char_pkg;
  // Register indices seen through the write port
  localparam int IDX_HTOT  = 0;
  localparam int IDX_HDISP = 1;
  localparam int IDX_HSPOS = 2;
  localparam int IDX_SWID  = 3;
  localparam int IDX_VTOT  = 4;
  localparam int IDX_VADJ  = 5;
  localparam int IDX_VDISP = 6;
  localparam int IDX_VSPOS = 7;
  localparam int IDX_MAXSL = 9;
  localparam int IDX_BHI   = 12;
  localparam int IDX_BLO   = 13;
endpackage

// File: rtl/crt_char_regs.sv
module crt_char_regs
  import crt_char_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 5,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_we,
  input  logic [IW-1:0] sel_idx,
  input  logic          dat_we,
  input  logic [DW-1:0] dat,
  output logic [DW-1:0] r_htot,
  output logic [DW-1:0] r_hdisp,
  output logic [DW-1:0] r_hsp,
  output logic [DW-1:0] r_sw,
  output logic [DW-1:0] r_vtot,
  output logic [DW-1:0] r_vadj,
  output logic [DW-1:0] r_vdisp,
  output logic [DW-1:0] r_vsp,
  output logic [DW-1:0] r_maxsl,
  output logic [AW-1:0] start
);
  localparam int HIW = AW - DW;

  logic [IW-1:0]  sel_q;
  logic [HIW-1:0] base_hi;
  logic [DW-1:0]  base_lo;

  assign start = {base_hi, base_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      r_htot  <= '0;
      r_hdisp <= '0;
      r_hsp   <= '0;
      r_sw    <= '0;
      r_vtot  <= '0;
      r_vadj  <= '0;
      r_vdisp <= '0;
      r_vsp   <= '0;
      r_maxsl <= '0;
      base_hi <= '0;
      base_lo <= '0;
    end else begin
      if (sel_we) sel_q <= sel_idx;
      if (dat_we) begin
        case (int'(sel_q))
          IDX_HTOT:  r_htot  <= dat;
          IDX_HDISP: r_hdisp <= dat;
          IDX_HSPOS: r_hsp   <= dat;
          IDX_SWID:  r_sw    <= dat;
          IDX_VTOT:  r_vtot  <= dat;
          IDX_VADJ:  r_vadj  <= dat;
          IDX_VDISP: r_vdisp <= dat;
          IDX_VSPOS: r_vsp   <= dat;
          IDX_MAXSL: r_maxsl <= dat;
          IDX_BHI:   base_hi <= dat[HIW-1:0];
          IDX_BLO:   base_lo <= dat;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/crt_char_hgen.sv
module crt_char_hgen #(
  parameter int HW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] h_total,
  input  logic [DW-1:0] h_spos,
  input  logic [3:0]    hs_width,
  output logic [HW-1:0] hcc,
  output logic          line_end,
  output logic          hsync
);
  logic [3:0] hs_cnt;

  assign line_end = (DW'(hcc) == h_total);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcc    <= '0;
      hsync  <= 1'b0;
      hs_cnt <= '0;
    end else begin
      hcc <= line_end ? '0 : hcc + 1'b1;
      if (!hsync && DW'(hcc) == h_spos && hs_width != 4'd0) begin
        hsync  <= 1'b1;
        hs_cnt <= '0;
      end else if (hsync) begin
        if (4'(hs_cnt + 1'b1) == hs_width) hsync <= 1'b0;
        else hs_cnt <= hs_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crt_char_vgen.sv
module crt_char_vgen #(
  parameter int VW = 7,
  parameter int RW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [DW-1:0] v_total,
  input  logic [DW-1:0] v_adj,
  input  logic [DW-1:0] v_disp,
  input  logic [DW-1:0] v_spos,
  input  logic [DW-1:0] max_sl,
  input  logic [3:0]    vs_width,
  output logic [RW-1:0] sl,
  output logic [VW-1:0] row,
  output logic          in_adj,
  output logic          row_step,
  output logic          frame_start,
  output logic          v_active,
  output logic          vsync
);
  localparam int VSCW = 5;

  logic [RW-1:0]   adj_cnt;
  logic [VSCW-1:0] vs_cnt;
  logic [VSCW-1:0] vs_len;
  logic            row_last, sl_last, adj_last, vs_start;

  assign vs_len   = (vs_width == 4'd0) ? VSCW'(16) : VSCW'(vs_width);
  assign sl_last  = (DW'(sl) == max_sl);
  assign row_last = (DW'(row) == v_total);
  assign adj_last = (DW'(adj_cnt) + DW'(1) == v_adj);

  assign frame_start = line_end && (in_adj ? adj_last
                                           : (sl_last && row_last && v_adj == '0));
  assign row_step    = line_end && !in_adj && sl_last && !row_last;
  assign vs_start    = (row_step && DW'(VW'(row + 1'b1)) == v_spos) ||
                       (frame_start && v_spos == '0);
  assign v_active    = !in_adj && (DW'(row) < v_disp);

  always_ff @(posedge clk) begin
    if (rst) begin
      sl      <= '0;
      row     <= '0;
      in_adj  <= 1'b0;
      adj_cnt <= '0;
      vsync   <= 1'b0;
      vs_cnt  <= '0;
    end else if (line_end) begin
      if (frame_start) begin
        sl      <= '0;
        row     <= '0;
        in_adj  <= 1'b0;
        adj_cnt <= '0;
      end else if (in_adj) begin
        adj_cnt <= adj_cnt + 1'b1;
        sl      <= sl + 1'b1;
      end else if (sl_last) begin
        sl <= '0;
        if (row_last) begin
          in_adj  <= 1'b1;
          adj_cnt <= '0;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        sl <= sl + 1'b1;
      end

      if (vs_start) begin
        vsync  <= 1'b1;
        vs_cnt <= '0;
      end else if (vsync) begin
        if (VSCW'(vs_cnt + 1'b1) == vs_len) vsync <= 1'b0;
        else vs_cnt <= vs_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crt_char_addr.sv
module crt_char_addr #(
  parameter int HW  = 8,
  parameter int DW  = 8,
  parameter int AW  = 14,
  parameter int RAB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     hcc,
  input  logic [DW-1:0]     h_disp,
  input  logic [AW-1:0]     start,
  input  logic [RAB-1:0]    ra,
  input  logic              row_step,
  input  logic              frame_start,
  input  logic              v_active,
  output logic              de,
  output logic [AW+RAB-1:0] vma
);
  logic [AW-1:0] row_base;
  logic          h_active;

  assign h_active = (DW'(hcc) < h_disp);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base <= '0;
      de       <= 1'b0;
      vma      <= '0;
    end else begin
      if (frame_start)   row_base <= start;
      else if (row_step) row_base <= row_base + AW'(h_disp);
      de  <= h_active && v_active;
      vma <= {AW'(row_base + AW'(hcc)), ra};
    end
  end
endmodule

// File: rtl/crt_char_timer.sv
module crt_char_timer #(
  parameter int HW  = 8,
  parameter int VW  = 7,
  parameter int RW  = 5,
  parameter int DW  = 8,
  parameter int IW  = 5,
  parameter int AW  = 14,
  parameter int RAB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [IW-1:0]     sel_idx,
  input  logic              dat_we,
  input  logic [DW-1:0]     dat,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [AW+RAB-1:0] vma
);
  logic [DW-1:0] r_htot, r_hdisp, r_hsp, r_sw, r_vtot, r_vadj, r_vdisp, r_vsp, r_maxsl;
  logic [AW-1:0] start;
  logic [HW-1:0] hcc;
  logic [RW-1:0] sl;
  logic [VW-1:0] row;
  logic          line_end, in_adj, row_step, frame_start, v_active;

  crt_char_regs #(.DW(DW), .IW(IW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_idx(sel_idx),
    .dat_we(dat_we), .dat(dat),
    .r_htot(r_htot), .r_hdisp(r_hdisp), .r_hsp(r_hsp), .r_sw(r_sw),
    .r_vtot(r_vtot), .r_vadj(r_vadj), .r_vdisp(r_vdisp), .r_vsp(r_vsp),
    .r_maxsl(r_maxsl), .start(start)
  );

  crt_char_hgen #(.HW(HW), .DW(DW)) u_hgen (
    .clk(clk), .rst(rst), .h_total(r_htot), .h_spos(r_hsp),
    .hs_width(r_sw[3:0]), .hcc(hcc), .line_end(line_end), .hsync(hsync)
  );

  crt_char_vgen #(.VW(VW), .RW(RW), .DW(DW)) u_vgen (
    .clk(clk), .rst(rst), .line_end(line_end),
    .v_total(r_vtot), .v_adj(r_vadj), .v_disp(r_vdisp), .v_spos(r_vsp),
    .max_sl(r_maxsl), .vs_width(r_sw[7:4]),
    .sl(sl), .row(row), .in_adj(in_adj), .row_step(row_step),
    .frame_start(frame_start), .v_active(v_active), .vsync(vsync)
  );

  crt_char_addr #(.HW(HW), .DW(DW), .AW(AW), .RAB(RAB)) u_addr (
    .clk(clk), .rst(rst), .hcc(hcc), .h_disp(r_hdisp), .start(start),
    .ra(sl[RAB-1:0]), .row_step(row_step), .frame_start(frame_start),
    .v_active(v_active), .de(de), .vma(vma)
  );
endmodule

// File: rtl/crt_char_checker.sv
module crt_char_checker #(
  parameter int HW = 8,
  parameter int VW = 7,
  parameter int RW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          line_end,
  input logic          frame_start,
  input logic          in_adj,
  input logic [HW-1:0] hcc,
  input logic [DW-1:0] h_spos,
  input logic [DW-1:0] h_disp,
  input logic [RW-1:0] sl,
  input logic [VW-1:0] row
);
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    line_end |=> hcc == '0);

  p_de_hdisp_r4: assert property (@(posedge clk) disable iff (rst)
    de |-> DW'($past(hcc)) < $past(h_disp));

  p_hs_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> DW'($past(hcc)) == $past(h_spos));

  p_adj_blank_r6: assert property (@(posedge clk) disable iff (rst)
    in_adj |=> !de);

  p_frame_restart_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (row == '0 && sl == '0 && !in_adj));

  p_vs_row_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (hcc == '0 && sl == '0));
endmodule

bind crt_char_timer crt_char_checker #(.HW(HW), .VW(VW), .RW(RW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
  .line_end(line_end), .frame_start(frame_start), .in_adj(in_adj),
  .hcc(hcc), .h_spos(r_hsp), .h_disp(r_hdisp), .sl(sl), .row(row)
);

// File: tb/crt_char_timer_bench.sv
module crt_char_timer_bench;
  localparam int AW  = 14;
  localparam int RAB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_we = 1'b0, dat_we = 1'b0;
  logic [4:0] sel_idx = '0;
  logic [7:0] dat = '0;
  logic hsync, vsync, de;
  logic [AW+RAB-1:0] vma;

  always #4 clk = ~clk;

  crt_char_timer u_crt_char_timer (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_idx(sel_idx),
    .dat_we(dat_we), .dat(dat), .hsync(hsync), .vsync(vsync), .de(de), .vma(vma)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int r0, r1, r2, r3, r4, r5, r6, r7, r9, sa;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int val);
    @(negedge clk); sel_we = 1'b1; sel_idx = 5'(idx);
    @(negedge clk); sel_we = 1'b0; dat_we = 1'b1; dat = 8'(val);
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic program_cfg(int a0, int a1, int a2, int a3, int a4, int a5,
                             int a6, int a7, int a9, int asa);
    r0 = a0; r1 = a1; r2 = a2; r3 = a3; r4 = a4; r5 = a5;
    r6 = a6; r7 = a7; r9 = a9; sa = asa;
    wr(0, r0); wr(1, r1); wr(2, r2); wr(3, r3); wr(4, r4);
    wr(5, r5); wr(6, r6); wr(7, r7); wr(9, r9);
    wr(12, sa >> 8); wr(13, sa & 255);
  endtask

  task automatic reset_check();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(hsync == 1'b0, "R1 hsync", int'(hsync), 0);
    chk(vsync == 1'b0, "R1 vsync", int'(vsync), 0);
    chk(de == 1'b0, "R1 de", int'(de), 0);
    chk(vma == '0, "R1 vma", int'(vma), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  function automatic int exp_vma(int k);
    int row = k / (r9 + 1);
    int sln = k % (r9 + 1);
    return (((sa + row * r1) % (1 << AW)) << RAB) | (sln & ((1 << RAB) - 1));
  endfunction

  task automatic measure(string tag, output int first_lp);
    int t = 0, n = 0;
    int hs_r = -1, vs_r = -1, de_r = -1, fstart = -1, k = 0, de_cnt = 0;
    bit have_fr = 0, ph, pv, pd;
    int lp = r0 + 1;
    int vsw = ((r3 >> 4) == 0) ? 16 : (r3 >> 4);
    int frame = ((r4 + 1) * (r9 + 1) + r5) * lp;
    logic [AW+RAB-1:0] pvma = '0;
    first_lp = -1;
    pv = vsync;
    while (n < 2) begin
      @(negedge clk);
      if (vsync && !pv) n++;
      pv = vsync;
    end
    ph = hsync; pd = de; n = 0;
    while (n < 4) begin
      @(negedge clk); t++;
      if (hsync && !ph) begin
        if (hs_r >= 0) begin
          chk(t - hs_r == lp, {"R3 line period ", tag}, t - hs_r, lp);
          if (first_lp < 0) first_lp = t - hs_r;
        end
        if (de_r >= 0 && t - de_r <= r0)
          chk(t - de_r == r2, {"R5 hsync offset ", tag}, t - de_r, r2);
        hs_r = t;
      end
      if (!hsync && ph && hs_r >= 0)
        chk(t - hs_r == (r3 & 15), {"R5 hsync width ", tag}, t - hs_r, r3 & 15);
      if (de && !pd) begin
        if (de_r >= 0 && t - de_r > lp) begin
          if (have_fr)
            chk(de_cnt == r1 * r6 * (r9 + 1), {"R7 de per frame ", tag},
                de_cnt, r1 * r6 * (r9 + 1));
          have_fr = 1; fstart = t; k = 0; de_cnt = 0;
        end else if (have_fr) k++;
        de_r = t;
        if (have_fr)
          chk(int'(vma) == exp_vma(k), {"R9 row start address ", tag}, int'(vma), exp_vma(k));
      end else if (de && pd && have_fr) begin
        chk(vma == (AW+RAB)'(pvma + (1 << RAB)), {"R9 column step ", tag},
            int'(vma), int'((AW+RAB)'(pvma + (1 << RAB))));
      end
      if (de) de_cnt++;
      if (!de && pd && de_r >= 0)
        chk(t - de_r == r1, {"R4 de width ", tag}, t - de_r, r1);
      if (vsync && !pv) begin
        if (vs_r >= 0) chk(t - vs_r == frame, {"R6 frame period ", tag}, t - vs_r, frame);
        if (have_fr)
          chk(t - fstart == r7 * (r9 + 1) * lp - 1, {"R8 vsync row ", tag},
              t - fstart, r7 * (r9 + 1) * lp - 1);
        vs_r = t; n++;
      end
      if (!vsync && pv && vs_r >= 0)
        chk(t - vs_r == vsw * lp, {"R8 vsync width ", tag}, t - vs_r, vsw * lp);
      ph = hsync; pv = vsync; pd = de; pvma = vma;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lp;
    reset_check();
    // Config A: plain timing, row base at 0x123
    program_cfg(19, 12, 14, 8'h23, 9, 0, 6, 7, 3, 16'h0123);
    measure("A", lp);
    chk(lp == r0 + 1, "R2 register load", lp, r0 + 1);
    // Writes through unimplemented indices must leave timing alone
    wr(10, 1); wr(11, 1); wr(8, 1); wr(15, 1); wr(31, 1);
    measure("A after ignored writes R10", lp);
    chk(lp == r0 + 1, "R10 ignored indices", lp, r0 + 1);
    // Config B: hsync position equals line total, adjust lines, 16-line vsync, address wrap
    reset_check();
    program_cfg(15, 10, 15, 8'h04, 7, 3, 5, 2, 2, 16'h3FF0);
    measure("B", lp);
    // Config C: one-clock hsync, 15-line vsync, single scan line rows, one adjust line
    reset_check();
    program_cfg(7, 3, 5, 8'hF1, 20, 1, 20, 1, 0, 0);
    measure("C", lp);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule